// File: doc/BRIEF.md
# Serial clock source selector

This block sits between a serial port's baud generator, its shift logic and the shared serial-clock pin. A two-bit clock-enable code together with a mode bit (asynchronous or clocked synchronous) decides where the serial timing comes from and what the pin does. The timing source is either the internal 16x baud tick or edges taken from the pin. The pin acts as a general I/O port, as a clock output or as a clock input.

In asynchronous mode the block delivers a 16x oversample tick to the receiver and transmitter. In clocked synchronous mode it delivers one tick per bit. When the internal clock is brought out on the pin, the internal 16x tick is divided by 16 to make a square wave at the bit rate. The pin input passes through a two-flop synchronizer, and each rising edge becomes a single-cycle tick. The baud-rate divider and the shift registers are outside this block.

Top module: `sclk_src_sel`

## Requirements
- R1: After reset, with the code at 00, the mode asynchronous and the internal tick and pin low, the pin output-enable, the pin output value, the oversample tick and the bit tick are all 0.
- R2: In asynchronous mode with code 00, the pin output-enable stays 0 and the oversample tick equals the internal 16x tick in the same cycle.
- R3: In asynchronous mode with code 01, the pin output-enable is 1 and the pin output is a 50% duty square wave. It is high while the divide-by-16 count of internal ticks is 8 to 15 and low while the count is 0 to 7. The oversample tick still follows the internal tick.
- R4: In asynchronous mode with code 10 or 11, the pin output-enable is 0 and internal ticks have no effect. The oversample tick pulses once for each rising pin edge. It is high in the second cycle after the cycle in which the pin is first sampled high.
- R5: In synchronous mode with code 00 or 01, the pin output-enable is 1 and the pin carries the divided square wave. The bit tick pulses together with the internal tick that moves the count from 15 back to 0.
- R6: In synchronous mode with code 10 or 11, the pin output-enable is 0 and internal ticks have no effect. The bit tick pulses once for each rising pin edge, with the same latency as in R4.
- R7: The oversample tick is never active in synchronous mode, and the bit tick is never active in asynchronous mode. The two ticks are never high together.
- R8: An external tick lasts exactly one cycle even while the pin stays high. A falling pin edge produces no tick.
- R9: While the code's upper bit is 1, the divide-by-16 count is held at 0. After a return to an internal code, the pin output stays low for the first 8 internal ticks.
- R10: The pin output value is 0 whenever the pin output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 2 | Clock-enable code: bit 1 selects the external source, bit 0 requests clock output in asynchronous mode |
| sync_mode_i | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| int_tick16_i | input | 1 | Internal baud tick at 16 times the bit rate, one cycle wide |
| sck_pin_i | input | 1 | Level read from the serial-clock pin |
| os_tick_o | output | 1 | 16x oversample tick toward the asynchronous shift logic |
| bit_tick_o | output | 1 | Bit tick toward the synchronous shift logic |
| sck_oe_o | output | 1 | Output-enable for the serial-clock pin |
| sck_out_o | output | 1 | Value driven onto the serial-clock pin |

## Verification
Two things can land on the same cycle: a synchronized external edge and an internal 16x tick. Likewise, the divider wrap that makes a synchronous bit tick can coincide with a pin edge that is ignored. The bench holds the internal tick high for many consecutive cycles while it raises the pin, so that the edge appears during a run of internal ticks. It does this under both internal and external codes in both modes. It then counts the ticks in the window: only the selected source may show, and exactly the expected number of pulses must appear.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ROLE_GPIO    = 2'd0,
        ROLE_CLK_OUT = 2'd1,
        ROLE_CLK_IN  = 2'd2
    } pin_role_e;

endpackage

// File: rtl/sclk_pin_sync.sv
module sclk_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int N = SYNC_STAGES + 1;

    typedef struct packed {
        logic [N-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[N-2:0], pin_i};
        rise_o  = st_q.sh[N-2] & ~st_q.sh[N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R8

endmodule

// File: rtl/sclk_baud_div.sv
module sclk_baud_div #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic wrap_o,
    output logic phase_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OVERSAMPLE / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i)
            st_d.cnt = '0;
        else if (tick_i)
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        wrap_o  = tick_i & ~hold_i & (st_q.cnt == LAST);
        phase_o = (st_q.cnt >= HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.cnt == '0)); // R9

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !hold_i && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R3

endmodule

// File: rtl/sclk_role_dec.sv
module sclk_role_dec
    import sclk_pkg::*;
(
    input  logic [1:0] cke_i,
    input  logic       sync_mode_i,
    output pin_role_e  role_o,
    output logic       use_ext_o
);
    always_comb begin
        use_ext_o = cke_i[1];
        if (cke_i[1])
            role_o = ROLE_CLK_IN;
        else if (sync_mode_i || cke_i[0])
            role_o = ROLE_CLK_OUT;
        else
            role_o = ROLE_GPIO;
    end
endmodule

// File: rtl/sclk_src_sel.sv
module sclk_src_sel
    import sclk_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cke_i,
    input  logic       sync_mode_i,
    input  logic       int_tick16_i,
    input  logic       sck_pin_i,
    output logic       os_tick_o,
    output logic       bit_tick_o,
    output logic       sck_oe_o,
    output logic       sck_out_o
);
    pin_role_e role;
    logic      use_ext;
    logic      ext_rise;
    logic      div_wrap;
    logic      div_phase;
    logic      src_tick;

    sclk_role_dec u_dec (
        .cke_i       (cke_i),
        .sync_mode_i (sync_mode_i),
        .role_o      (role),
        .use_ext_o   (use_ext)
    );

    sclk_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sck_pin_i),
        .rise_o (ext_rise)
    );

    sclk_baud_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (int_tick16_i),
        .hold_i  (use_ext),
        .wrap_o  (div_wrap),
        .phase_o (div_phase)
    );

    always_comb begin
        if (sync_mode_i)
            src_tick = use_ext ? ext_rise : div_wrap;
        else
            src_tick = use_ext ? ext_rise : int_tick16_i;
        os_tick_o  = src_tick & ~sync_mode_i;
        bit_tick_o = src_tick &  sync_mode_i;
        sck_oe_o   = (role == ROLE_CLK_OUT);
        sck_out_o  = sck_oe_o & div_phase;
    end

    AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(os_tick_o && bit_tick_o)); // R7

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe_o |-> !sck_out_o); // R10

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_i[1] |-> !sck_oe_o); // R4

    AST_EXT_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_i[1] && (os_tick_o || bit_tick_o)) |-> ext_rise); // R6

endmodule

// File: tb/test_sclk_src_sel.sv
module test_sclk_src_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cke = 2'b00;
    logic       sync_mode = 1'b0;
    logic       itick = 1'b0;
    logic       pin = 1'b0;
    logic       os_tick, bit_tick, sck_oe, sck_out;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sclk_src_sel i_sclk_src_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_i        (cke),
        .sync_mode_i  (sync_mode),
        .int_tick16_i (itick),
        .sck_pin_i    (pin),
        .os_tick_o    (os_tick),
        .bit_tick_o   (bit_tick),
        .sck_oe_o     (sck_oe),
        .sck_out_o    (sck_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_div();
        cke = 2'b10; itick = 1'b0;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        #1;
        chk("R1 oe", sck_oe, 0);
        chk("R1 out", sck_out, 0);
        chk("R1 os_tick", os_tick, 0);
        chk("R1 bit_tick", bit_tick, 0);
    endtask

    task automatic t_async_gpio();
        sync_mode = 1'b0; cke = 2'b00; itick = 1'b1;
        #1;
        chk("R2 os_tick follows", os_tick, 1);
        chk("R2 oe", sck_oe, 0);
        chk("R7 no bit tick async", bit_tick, 0);
        step();
        itick = 1'b0;
        #1;
        chk("R2 os_tick idle", os_tick, 0);
    endtask

    task automatic t_async_clkout();
        int highs = 0;
        sync_mode = 1'b0;
        clear_div();
        cke = 2'b01;
        for (int i = 0; i < 32; i++) begin
            itick = 1'b1;
            #1;
            if (sck_out) highs++;
            if (i == 0 || i == 7 || i == 8 || i == 15 || i == 16 || i == 24)
                chk("R3 square wave", sck_out, ((i % 16) >= 8) ? 1 : 0);
            if (i == 3) chk("R3 os_tick", os_tick, 1);
            step();
        end
        itick = 1'b0;
        #1;
        chk("R3 oe", sck_oe, 1);
        chk("R3 duty", highs, 16);
    endtask

    task automatic t_sync_int();
        int ticks = 0;
        sync_mode = 1'b1;
        clear_div();
        cke = 2'b01;
        for (int i = 0; i < 32; i++) begin
            itick = 1'b1;
            #1;
            if (bit_tick) ticks++;
            if (i == 14 || i == 15 || i == 31)
                chk("R5 bit tick on wrap", bit_tick, (i % 16 == 15) ? 1 : 0);
            if (i == 15) chk("R7 no os tick sync", os_tick, 0);
            step();
        end
        itick = 1'b0;
        #1;
        chk("R5 oe", sck_oe, 1);
        chk("R5 tick count", ticks, 2);
        cke = 2'b00;
        #1;
        chk("R5 oe code 00", sck_oe, 1);
    endtask

    task automatic t_ext(input bit smode, input logic [1:0] code, input string req);
        sync_mode = smode; cke = code; itick = 1'b1; pin = 1'b0;
        repeat (3) step();
        #1;
        chk({req, " internal ignored"}, os_tick | bit_tick, 0);
        chk({req, " oe"}, sck_oe, 0);
        chk("R10 out low", sck_out, 0);
        pin = 1'b1;
        step();
        #1;
        chk({req, " not yet"}, os_tick | bit_tick, 0);
        step();
        #1;
        chk({req, " tick"}, smode ? bit_tick : os_tick, 1);
        chk("R7 other tick", smode ? os_tick : bit_tick, 0);
        step();
        #1;
        chk("R8 single cycle", os_tick | bit_tick, 0);
        repeat (3) step();
        pin = 1'b0;
        repeat (4) begin
            step();
            #1;
            chk("R8 no fall tick", os_tick | bit_tick, 0);
        end
        itick = 1'b0;
    endtask

    task automatic t_collide(input bit smode, input logic [1:0] code,
                             input int exp_os, input int exp_bit, input string req);
        int os_n = 0;
        int bit_n = 0;
        sync_mode = smode;
        clear_div();
        cke = code; pin = 1'b0;
        for (int i = 0; i < 16; i++) begin
            itick = 1'b1;
            if (i == 12) pin = 1'b1;
            #1;
            os_n += int'(os_tick);
            bit_n += int'(bit_tick);
            step();
        end
        itick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            os_n += int'(os_tick);
            bit_n += int'(bit_tick);
            step();
        end
        pin = 1'b0;
        repeat (4) step();
        chk({req, " collide os count"}, os_n, exp_os);
        chk({req, " collide bit count"}, bit_n, exp_bit);
    endtask

    task automatic t_hold();
        sync_mode = 1'b0; cke = 2'b00;
        for (int i = 0; i < 11; i++) begin
            itick = 1'b1;
            step();
        end
        itick = 1'b0;
        cke = 2'b11;
        step();
        cke = 2'b01;
        for (int i = 0; i < 9; i++) begin
            itick = 1'b1;
            #1;
            if (i == 0 || i == 7 || i == 8)
                chk("R9 restart phase", sck_out, (i >= 8) ? 1 : 0);
            step();
        end
        itick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_async_gpio();
        t_async_clkout();
        t_sync_int();
        t_ext(1'b0, 2'b10, "R4");
        t_ext(1'b0, 2'b11, "R4");
        t_ext(1'b1, 2'b10, "R6");
        t_ext(1'b1, 2'b11, "R6");
        t_collide(1'b0, 2'b10, 1, 0, "R4");
        t_collide(1'b1, 2'b11, 0, 1, "R6");
        t_collide(1'b1, 2'b00, 0, 1, "R5");
        t_collide(1'b0, 2'b01, 16, 0, "R3");
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule